// File: doc/BRIEF.md
# Canonical Huffman Table Builder

This block turns the two standard baseline table-definition lists into encoder lookup tables. A host writes one byte per cycle on a programming port. For a table it first sends sixteen bytes holding how many codes exist at each code length, then the symbol values in order of increasing code length. The block assigns canonical codewords as the bytes arrive and keeps four independent tables: DC and AC, each for luminance and chrominance.

An entropy encoder then presents a table number and a symbol on the lookup port. One clock edge later it receives the code length and the right-aligned codeword. To keep storage small, each symbol slot holds only a present flag and the symbol's position in its values list. Per table and per length, an ending position and a code offset are kept. The length and the codeword are rebuilt from these at lookup time.

A table that is being redefined is flagged busy, and the encoder must not look it up until the flag drops.

Top module: `huff_table_builder`

## Requirements
- R1: After reset every lookup in every table returns length 0 and code 0, and `tbl_busy` is all zeros.
- R2: Table numbers are encoded as follows: bit 1 is 0 for DC and 1 for AC; bit 0 is 0 for luminance and 1 for chrominance. `prog_table` is sampled only with the first count byte of a definition and is ignored for the rest of that definition.
- R3: A definition is exactly 16 count bytes (byte k = number of codes of length k+1), followed by as many value bytes as the counts add up to. Cycles with `prog_valid` low are ignored whatever `prog_byte` and `prog_table` hold.
- R4: Codes are canonical. The first code of the shortest used length is 0. Each further symbol takes the previous code plus one, and each step to the next length shifts the running code left by one. The code sits in the low `look_len` bits of `look_code`, and the bits above are 0.
- R5: `look_len` and `look_code` answer the `look_table` and `look_sym` sampled at the previous rising clock edge, and hold until the next edge.
- R6: A symbol not in the current definition of a table reads length 0 and code 0. Starting a new definition removes every symbol of the previous one.
- R7: The DC tables hold only symbols below 2^`DC_SYM_W` (16 by default). A larger value in a DC values list uses up its code position but is not stored, and looking it up gives length 0.
- R8: No idle cycle is needed between the last count byte and the first value byte, nor between the last byte of one definition and the first count byte of the next.
- R9: `tbl_busy[t]` is 1 from the cycle after the first count byte of table t is accepted until the cycle after its last byte is accepted. At most one bit is ever set.
- R10: When all 16 counts are zero, no value bytes follow. The table ends up empty and the next byte is a first count byte.
- R11: A table may hold all 256 symbols, with codes up to 16 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_valid | input | 1 | Qualifies `prog_byte` |
| prog_table | input | 2 | Table number, sampled with the first count byte |
| prog_byte | input | 8 | Count or symbol value byte |
| tbl_busy | output | 4 | One bit per table, set while that table is being redefined |
| look_table | input | 2 | Table number for a lookup |
| look_sym | input | 8 | Symbol to look up |
| look_len | output | 5 | Code length, 0 when the symbol is absent |
| look_code | output | 16 | Right-aligned codeword |

## Verification
The bench computes the canonical code of every symbol itself and sweeps all 256 symbols of every table. The tables cover a fully populated 256-symbol AC table reaching 16-bit codes, an empty table and DC lists holding values 16 and above. A wrong shift or offset at a length boundary corrupts every later code in that table. Position arithmetic that wraps badly breaks the last symbol or the 16-bit codes. A DC store without a range check aliases value 16 onto symbol 0. The definitions are streamed back to back, and `prog_table` is changed in the middle of one values list. A design that needed a gap cycle, or that followed the select mid-list, would corrupt the next table or write into a neighbouring one. A redefinition with idle cycles carrying junk must not keep stale symbols or consume the junk bytes, and the busy flag is checked at the exact cycle it should rise and fall.

// File: rtl/huff_tbl_pkg.sv
package huff_tbl_pkg;
   localparam int unsigned NTBL  = 4;
   localparam int unsigned TBL_W = 2;

   typedef enum logic [0:0] {
      ST_COUNTS = 1'b0,
      ST_VALUES = 1'b1
   } prog_st_e;

   function automatic logic tbl_is_dc(input logic [TBL_W-1:0] t);
      return ~t[1];
   endfunction
endpackage

// File: rtl/huff_prog_fsm.sv
module huff_prog_fsm
   import huff_tbl_pkg::*;
#(
   parameter int unsigned SYM_W  = 8,
   parameter int unsigned CODE_W = 16,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned END_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [TBL_W-1:0]  in_tbl,
   input  logic [SYM_W-1:0]  in_byte,
   output logic              meta_we,
   output logic [TBL_W-1:0]  meta_tbl,
   output logic [IDX_W-1:0]  meta_idx,
   output logic [CODE_W-1:0] meta_offs,
   output logic [END_W-1:0]  meta_end,
   output logic              clr_we,
   output logic [TBL_W-1:0]  clr_tbl,
   output logic              sym_we,
   output logic [TBL_W-1:0]  sym_tbl,
   output logic [SYM_W-1:0]  sym_val,
   output logic [SYM_W-1:0]  sym_ord,
   output logic [NTBL-1:0]   busy
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);
   localparam logic [CNT_W-1:0] ORD_LIM  = CNT_W'(1 << SYM_W);

   prog_st_e          st_q;
   logic [IDX_W-1:0]  idx_q;
   logic [TBL_W-1:0]  tbl_q;
   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  cum_q;
   logic [CNT_W-1:0]  remain_q;
   logic [SYM_W-1:0]  ord_q;
   logic [NTBL-1:0]   busy_q;

   logic              first;
   logic [TBL_W-1:0]  cur_tbl;
   logic [CODE_W-1:0] base_code;
   logic [CNT_W-1:0]  base_cum;
   logic [CODE_W-1:0] code_sum;
   logic [CODE_W-1:0] code_nx;
   logic [CNT_W-1:0]  cum_nx;

   always_comb begin
      first     = (st_q == ST_COUNTS) && (idx_q == '0);
      cur_tbl   = first ? in_tbl : tbl_q;
      base_code = first ? '0 : code_q;
      base_cum  = first ? '0 : cum_q;
      code_sum  = base_code + CODE_W'(in_byte);
      code_nx   = code_sum << 1;
      cum_nx    = base_cum + CNT_W'(in_byte);
   end

   // per-length record: code offset relative to list position, and end position
   assign meta_we   = in_valid && (st_q == ST_COUNTS);
   assign meta_tbl  = cur_tbl;
   assign meta_idx  = idx_q;
   assign meta_offs = base_code - CODE_W'(base_cum);
   assign meta_end  = (cum_nx > ORD_LIM) ? END_W'(ORD_LIM) : END_W'(cum_nx);

   assign clr_we  = in_valid && first;
   assign clr_tbl = in_tbl;

   assign sym_we  = in_valid && (st_q == ST_VALUES);
   assign sym_tbl = tbl_q;
   assign sym_val = in_byte;
   assign sym_ord = ord_q;

   assign busy = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_COUNTS;
         idx_q    <= '0;
         tbl_q    <= '0;
         code_q   <= '0;
         cum_q    <= '0;
         remain_q <= '0;
         ord_q    <= '0;
         busy_q   <= '0;
      end else if (in_valid) begin
         if (st_q == ST_COUNTS) begin
            tbl_q  <= cur_tbl;
            code_q <= code_nx;
            cum_q  <= cum_nx;
            if (first) busy_q[in_tbl] <= 1'b1;
            if (idx_q == LAST_IDX) begin
               idx_q    <= '0;
               ord_q    <= '0;
               remain_q <= cum_nx;
               if (cum_nx == '0) busy_q[cur_tbl] <= 1'b0;
               else              st_q <= ST_VALUES;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end else begin
            ord_q    <= ord_q + SYM_W'(1);
            remain_q <= remain_q - CNT_W'(1);
            if (remain_q == CNT_W'(1)) begin
               st_q          <= ST_COUNTS;
               busy_q[tbl_q] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/huff_sym_store.sv
module huff_sym_store #(
   parameter int unsigned SYM_W = 8,
   parameter int unsigned IDX_W = 8,
   parameter int unsigned ORD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [SYM_W-1:0] wr_sym,
   input  logic [ORD_W-1:0] wr_ord,
   input  logic [SYM_W-1:0] rd_sym,
   output logic             rd_hit,
   output logic [ORD_W-1:0] rd_ord
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] vld_q;
   logic [ORD_W-1:0] ord_mem [DEPTH];
   logic             wr_ok;
   logic             rd_ok;

   generate
      if (IDX_W > SYM_W || IDX_W < 1) begin : g_bad_idx
         $error("huff_sym_store: IDX_W must lie in 1..SYM_W");
      end
      if (IDX_W == SYM_W) begin : g_full
         assign wr_ok = 1'b1;
         assign rd_ok = 1'b1;
      end else begin : g_narrow
         assign wr_ok = (wr_sym[SYM_W-1:IDX_W] == '0);
         assign rd_ok = (rd_sym[SYM_W-1:IDX_W] == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         rd_hit <= 1'b0;
      end else begin
         if (clr)                vld_q <= '0;
         else if (wr_en && wr_ok) vld_q[wr_sym[IDX_W-1:0]] <= 1'b1;
         rd_hit <= rd_ok && vld_q[rd_sym[IDX_W-1:0]];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_ok) ord_mem[wr_sym[IDX_W-1:0]] <= wr_ord;
      rd_ord <= ord_mem[rd_sym[IDX_W-1:0]];
   end
endmodule

// File: rtl/huff_code_calc.sv
module huff_code_calc #(
   parameter int unsigned CODE_W = 16,
   parameter int unsigned ORD_W  = 8,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned END_W  = 9,
   parameter int unsigned LEN_W  = 5
) (
   input  logic              hit,
   input  logic [ORD_W-1:0]  ord,
   input  logic [CODE_W-1:0] offs [CODE_W],
   input  logic [END_W-1:0]  ends [CODE_W-1],
   output logic [LEN_W-1:0]  len,
   output logic [CODE_W-1:0] code
);
   logic [IDX_W-1:0] below;

   // number of lengths whose symbols all precede this list position
   always_comb begin
      below = '0;
      for (int k = 0; k < CODE_W - 1; k++) begin
         if (ends[k] <= END_W'(ord)) below = below + IDX_W'(1);
      end
   end

   always_comb begin
      if (hit) begin
         len  = LEN_W'(below) + LEN_W'(1);
         code = CODE_W'(ord) + offs[below];
      end else begin
         len  = '0;
         code = '0;
      end
   end
endmodule

// File: rtl/huff_table_builder.sv
module huff_table_builder
   import huff_tbl_pkg::*;
#(
   parameter int unsigned SYM_W    = 8,
   parameter int unsigned DC_SYM_W = 4,
   parameter int unsigned CODE_W   = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           prog_valid,
   input  logic [1:0]                     prog_table,
   input  logic [SYM_W-1:0]               prog_byte,
   output logic [3:0]                     tbl_busy,
   input  logic [1:0]                     look_table,
   input  logic [SYM_W-1:0]               look_sym,
   output logic [$clog2(CODE_W+1)-1:0]    look_len,
   output logic [CODE_W-1:0]              look_code
);
   localparam int unsigned LEN_W = $clog2(CODE_W + 1);
   localparam int unsigned IDX_W = $clog2(CODE_W);
   localparam int unsigned CNT_W = SYM_W + IDX_W;
   localparam int unsigned ORD_W = SYM_W;
   localparam int unsigned END_W = ORD_W + 1;

   generate
      if (CODE_W < 2 || CODE_W > 32) begin : g_bad_code
         $error("huff_table_builder: CODE_W must lie in 2..32");
      end
      if (DC_SYM_W < 1 || DC_SYM_W > SYM_W) begin : g_bad_dc
         $error("huff_table_builder: DC_SYM_W must lie in 1..SYM_W");
      end
   endgenerate

   logic              meta_we;
   logic [TBL_W-1:0]  meta_tbl;
   logic [IDX_W-1:0]  meta_idx;
   logic [CODE_W-1:0] meta_offs;
   logic [END_W-1:0]  meta_end;
   logic              clr_we;
   logic [TBL_W-1:0]  clr_tbl;
   logic              sym_we;
   logic [TBL_W-1:0]  sym_tbl;
   logic [SYM_W-1:0]  sym_val;
   logic [ORD_W-1:0]  sym_ord;

   huff_prog_fsm #(
      .SYM_W (SYM_W),
      .CODE_W(CODE_W),
      .CNT_W (CNT_W),
      .IDX_W (IDX_W),
      .END_W (END_W)
   ) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (prog_valid),
      .in_tbl   (prog_table),
      .in_byte  (prog_byte),
      .meta_we  (meta_we),
      .meta_tbl (meta_tbl),
      .meta_idx (meta_idx),
      .meta_offs(meta_offs),
      .meta_end (meta_end),
      .clr_we   (clr_we),
      .clr_tbl  (clr_tbl),
      .sym_we   (sym_we),
      .sym_tbl  (sym_tbl),
      .sym_val  (sym_val),
      .sym_ord  (sym_ord),
      .busy     (tbl_busy)
   );

   // per-table, per-length records
   logic [CODE_W-1:0] offs_q [NTBL][CODE_W];
   logic [END_W-1:0]  end_q  [NTBL][CODE_W-1];

   always_ff @(posedge clk) begin
      if (meta_we) begin
         offs_q[meta_tbl][meta_idx] <= meta_offs;
         if (meta_idx != IDX_W'(CODE_W - 1)) end_q[meta_tbl][meta_idx] <= meta_end;
      end
   end

   // symbol stores: DC tables narrow, AC tables full width
   logic             rd_hit [NTBL];
   logic [ORD_W-1:0] rd_ord [NTBL];

   generate
      for (genvar t = 0; t < NTBL; t++) begin : g_tbl
         localparam int unsigned SW = tbl_is_dc(TBL_W'(t)) ? DC_SYM_W : SYM_W;
         huff_sym_store #(
            .SYM_W(SYM_W),
            .IDX_W(SW),
            .ORD_W(ORD_W)
         ) i_store (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_we && (clr_tbl == TBL_W'(t))),
            .wr_en (sym_we && (sym_tbl == TBL_W'(t))),
            .wr_sym(sym_val),
            .wr_ord(sym_ord),
            .rd_sym(look_sym),
            .rd_hit(rd_hit[t]),
            .rd_ord(rd_ord[t])
         );
      end
   endgenerate

   logic [TBL_W-1:0]  sel_q;
   logic              hit_sel;
   logic [ORD_W-1:0]  ord_sel;
   logic [CODE_W-1:0] offs_sel [CODE_W];
   logic [END_W-1:0]  end_sel  [CODE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= look_table;
   end

   always_comb begin
      hit_sel = rd_hit[sel_q];
      ord_sel = rd_ord[sel_q];
      for (int k = 0; k < CODE_W; k++) offs_sel[k] = offs_q[sel_q][k];
      for (int k = 0; k < CODE_W - 1; k++) end_sel[k] = end_q[sel_q][k];
   end

   huff_code_calc #(
      .CODE_W(CODE_W),
      .ORD_W (ORD_W),
      .IDX_W (IDX_W),
      .END_W (END_W),
      .LEN_W (LEN_W)
   ) i_calc (
      .hit (hit_sel),
      .ord (ord_sel),
      .offs(offs_sel),
      .ends(end_sel),
      .len (look_len),
      .code(look_code)
   );
endmodule

// File: rtl/huff_table_builder_chk.sv
module huff_table_builder_chk #(
   parameter int unsigned SYM_W    = 8,
   parameter int unsigned DC_SYM_W = 4,
   parameter int unsigned CODE_W   = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        prog_valid,
   input logic [3:0]                  tbl_busy,
   input logic [1:0]                  look_table,
   input logic [SYM_W-1:0]            look_sym,
   input logic [$clog2(CODE_W+1)-1:0] look_len,
   input logic [CODE_W-1:0]           look_code
);
   // R9
   busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tbl_busy));

   // R3
   idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_valid |=> $stable(tbl_busy));

   // R9
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_busy != $past(tbl_busy)) |-> $past(prog_valid));

   // R7
   dc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!look_table[1] && (look_sym >= SYM_W'(1 << DC_SYM_W))) |=> (look_len == '0));

   // R4
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      look_len <= ($clog2(CODE_W+1))'(CODE_W));

   // R6
   absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (look_len == '0) |-> (look_code == '0));
endmodule

bind huff_table_builder huff_table_builder_chk #(
   .SYM_W   (SYM_W),
   .DC_SYM_W(DC_SYM_W),
   .CODE_W  (CODE_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prog_valid(prog_valid),
   .tbl_busy  (tbl_busy),
   .look_table(look_table),
   .look_sym  (look_sym),
   .look_len  (look_len),
   .look_code (look_code)
);

// File: tb/test_huff_table_builder.sv
module test_huff_table_builder;
   localparam int CLK_P = 10;
   localparam int DC_W  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_valid = 1'b0;
   logic [1:0]  prog_table = '0;
   logic [7:0]  prog_byte = '0;
   logic [3:0]  tbl_busy;
   logic [1:0]  look_table = '0;
   logic [7:0]  look_sym = '0;
   logic [4:0]  look_len;
   logic [15:0] look_code;

   int checks = 0;
   int errors = 0;

   int cnt_tb [4][16];
   int val_tb [4][256];
   int exp_len  [4][256];
   int exp_code [4][256];

   always #(CLK_P/2) clk = ~clk;

   huff_table_builder i_huff_table_builder (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_valid(prog_valid),
      .prog_table(prog_table),
      .prog_byte (prog_byte),
      .tbl_busy  (tbl_busy),
      .look_table(look_table),
      .look_sym  (look_sym),
      .look_len  (look_len),
      .look_code (look_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int total(input int t);
      int s = 0;
      for (int k = 0; k < 16; k++) s += cnt_tb[t][k];
      return s;
   endfunction

   // canonical assignment computed independently
   task automatic build_exp(input int t);
      int code = 0;
      int pos = 0;
      for (int s = 0; s < 256; s++) begin
         exp_len[t][s] = 0;
         exp_code[t][s] = 0;
      end
      for (int l = 1; l <= 16; l++) begin
         for (int j = 0; j < cnt_tb[t][l-1]; j++) begin
            int sym = val_tb[t][pos];
            if (!(t < 2 && sym >= (1 << DC_W))) begin
               exp_len[t][sym] = l;
               exp_code[t][sym] = code;
            end
            code++;
            pos++;
         end
         code = code << 1;
      end
   endtask

   task automatic put(input int t, input int b);
      prog_valid = 1'b1;
      prog_table = 2'(t);
      prog_byte  = 8'(b);
      @(negedge clk);
      prog_valid = 1'b0;
   endtask

   task automatic idle_junk(input int t);
      prog_valid = 1'b0;
      prog_table = 2'(t ^ 3);
      prog_byte  = 8'hA5;
      @(negedge clk);
   endtask

   // sel_vals: table number driven during the values list (R2)
   task automatic load(input int t, input int sel_vals, input bit gaps);
      int n = total(t);
      for (int k = 0; k < 16; k++) begin
         if (gaps) idle_junk(t);
         put(t, cnt_tb[t][k]);
         if (k == 0) chk(tbl_busy == 4'(1 << t), "R9 busy rise", int'(tbl_busy), 1 << t);
      end
      if (n == 0) chk(tbl_busy == 4'b0, "R10 busy after empty", int'(tbl_busy), 0);
      for (int i = 0; i < n; i++) begin
         if (gaps) idle_junk(t);
         put(sel_vals, val_tb[t][i]);
         if (i == n - 1) chk(tbl_busy == 4'b0, "R9 busy fall", int'(tbl_busy), 0);
         else if (i == 0) chk(tbl_busy == 4'(1 << t), "R9 busy held", int'(tbl_busy), 1 << t);
      end
      build_exp(t);
   endtask

   task automatic sweep(input int t, input string tag_hit, input string tag_miss);
      for (int s = 0; s < 256; s++) begin
         string tag;
         int exp;
         look_table = 2'(t);
         look_sym   = 8'(s);
         @(negedge clk);
         exp = (exp_len[t][s] << 16) | exp_code[t][s];
         if (exp_len[t][s] == 16) tag = "R11";
         else if (exp_len[t][s] != 0) tag = tag_hit;
         else if (t < 2 && s >= (1 << DC_W) && tag_miss != "R1") tag = "R7";
         else tag = tag_miss;
         chk({look_len, look_code} == 21'(exp), tag, int'({look_len, look_code}), exp);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // table contents
      for (int t = 0; t < 4; t++) for (int k = 0; k < 16; k++) cnt_tb[t][k] = 0;
      cnt_tb[0][1] = 1; cnt_tb[0][2] = 5;
      for (int k = 3; k < 9; k++) cnt_tb[0][k] = 1;
      for (int i = 0; i < 12; i++) val_tb[0][i] = 11 - i;
      cnt_tb[1][1] = 3;
      for (int k = 2; k < 12; k++) cnt_tb[1][k] = 1;
      for (int i = 0; i < 12; i++) val_tb[1][i] = (i * 5) % 12;
      val_tb[1][12] = 200;
      cnt_tb[2][1] = 2; cnt_tb[2][2] = 1; cnt_tb[2][3] = 1; cnt_tb[2][4] = 2;
      cnt_tb[2][9] = 50; cnt_tb[2][11] = 100; cnt_tb[2][15] = 100;
      for (int i = 0; i < 256; i++) val_tb[2][i] = (i * 37 + 11) % 256;
      for (int t = 0; t < 4; t++) for (int s = 0; s < 256; s++) begin
         exp_len[t][s] = 0;
         exp_code[t][s] = 0;
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tbl_busy == 4'b0, "R1 busy", int'(tbl_busy), 0);
      for (int t = 0; t < 4; t++) sweep(t, "R1", "R1");

      // back-to-back stream of all four tables; select moved during table 1 values
      load(0, 0, 1'b0);
      load(1, 0, 1'b0);
      load(2, 2, 1'b0);
      load(3, 3, 1'b0);
      sweep(0, "R2", "R6");
      sweep(1, "R8", "R6");
      sweep(2, "R4", "R6");
      sweep(3, "R10", "R10");

      // lookup timing
      look_table = 2'd2; look_sym = 8'd11;
      @(negedge clk);
      look_table = 2'd0; look_sym = 8'd3;
      #1;
      chk({look_len, look_code} == 21'((exp_len[2][11] << 16) | exp_code[2][11]), "R5 hold",
          int'({look_len, look_code}), (exp_len[2][11] << 16) | exp_code[2][11]);
      @(negedge clk);
      chk({look_len, look_code} == 21'((exp_len[0][3] << 16) | exp_code[0][3]), "R5 next",
          int'({look_len, look_code}), (exp_len[0][3] << 16) | exp_code[0][3]);

      // redefine table 0 with idle junk cycles in between
      for (int k = 0; k < 16; k++) cnt_tb[0][k] = 0;
      cnt_tb[0][2] = 2; cnt_tb[0][3] = 3; cnt_tb[0][4] = 2;
      for (int i = 0; i < 7; i++) val_tb[0][i] = i * 3 + 1;
      load(0, 0, 1'b1);
      sweep(0, "R3", "R6");
      sweep(1, "R8", "R6");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule